// File: doc/BRIEF.md
# Write-Subset Group Register Renamer

This block renames four instructions per cycle for a machine whose physical register file is split into two write subsets: even-numbered and odd-numbered registers. Every destination has to come from the subset picked for its instruction. Each subset therefore keeps its own free list. Each cycle the block counts how many destinations in the group go to each subset and draws exactly that many entries from each list.

A speculative map from logical to physical registers supplies source tags. A source that names the destination of an older valid instruction in the same group takes that instruction's new tag instead of the map entry. When the group is accepted, the map records the youngest writer of each logical register.

The subset for each slot comes from a per-instruction target vector. In round-robin mode it comes from the slot position instead: even slots draw from the even list and odd slots from the odd list. A group that either list cannot serve is stalled as a whole. Freed registers come back through a two-entry release port.

Top module: `ws_renamer`

## Requirements
- R1: After reset, logical register i maps to physical register i for i = 0..7. The even free list holds 8, 10, ..., 30 in ascending order and the odd list holds 9, 11, ..., 31 in ascending order.
- R2: When `rr_mode` is 0, a valid slot i gets a destination with bit 0 equal to `subset_vec[i]`, where 1 selects odd and 0 selects even.
- R3: Free lists are first-in first-out. Valid slots that target the same subset take consecutive entries of that list in slot order, with slot 0 first.
- R4: An accepted group removes from each list exactly as many entries as it has valid slots targeting that subset. The next group continues from the following entry.
- R5: A source of slot i that names the destination of a valid slot j < i takes the new tag of the youngest such slot j. Otherwise the source reads the map, and a slot's own destination never feeds its own sources.
- R6: After an accepted group, each logical register written by the group maps to the tag of its youngest writer. Logical registers the group does not write keep their mapping.
- R7: An invalid slot takes no free-list entry, changes no mapping and is never a bypass source.
- R8: When `rr_mode` is 1, slot i uses subset i mod 2 and `subset_vec` is ignored.
- R9: `stall` is 1 exactly when a list holds fewer entries than its subset's count for the group, including a group that needs entries from only one list. A stalled group changes neither the map nor either free list.
- R10: Each valid release entry goes to the tail of the list selected by bit 0 of its tag. Two releases to the same subset in one cycle enter in port order, with port 0 first.
- R11: A register released in a cycle cannot be allocated in that same cycle. The stall decision uses the list occupancy from before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 1 selects subsets by slot position |
| ins_valid | input | 4 | Per-slot instruction valid; a valid slot writes its destination |
| subset_vec | input | 4 | Per-slot target subset (1 = odd) |
| src_a_log | input | 12 | Logical source A, 3 bits per slot, slot 0 in the low bits |
| src_b_log | input | 12 | Logical source B, 3 bits per slot |
| dst_log | input | 12 | Logical destination, 3 bits per slot |
| rel_valid | input | 2 | Release entry valid |
| rel_tag | input | 10 | Released physical tags, 5 bits per entry |
| src_a_phys | output | 20 | Physical source A, 5 bits per slot |
| src_b_phys | output | 20 | Physical source B, 5 bits per slot |
| dst_phys | output | 20 | Newly allocated physical destination, 5 bits per slot |
| stall | output | 1 | Group cannot be served this cycle |

## Verification
The hardest state to reach is a subset list that is exactly exhausted while the other list still holds entries. Reaching it takes three full groups that all target the even subset. The fourth group then has to stall even though the odd list is untouched, and a one-slot even request has to stall the same way. The stimulus then releases even tags while an even request is waiting. This shows that the release is not usable in the same cycle, and that the tags come out afterwards in the order they were returned. Each scenario starts from reset, so the expected tags follow directly from the ascending initial lists.

// File: rtl/ws_renamer.sv
module ws_renamer #(
  parameter int NLOG  = 8,
  parameter int NPHYS = 32,
  parameter int GRP   = 4,
  parameter int NREL  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rr_mode,
  input  logic [GRP-1:0]                     ins_valid,
  input  logic [GRP-1:0]                     subset_vec,
  input  logic [GRP*$clog2(NLOG)-1:0]        src_a_log,
  input  logic [GRP*$clog2(NLOG)-1:0]        src_b_log,
  input  logic [GRP*$clog2(NLOG)-1:0]        dst_log,
  input  logic [NREL-1:0]                    rel_valid,
  input  logic [NREL*$clog2(NPHYS)-1:0]      rel_tag,
  output logic [GRP*$clog2(NPHYS)-1:0]       src_a_phys,
  output logic [GRP*$clog2(NPHYS)-1:0]       src_b_phys,
  output logic [GRP*$clog2(NPHYS)-1:0]       dst_phys,
  output logic                               stall
);
  localparam int LW    = $clog2(NLOG);
  localparam int PW    = $clog2(NPHYS);
  localparam int SUBN  = NPHYS / 2;
  localparam int SW    = $clog2(SUBN);
  localparam int CW    = $clog2(SUBN + 1);
  localparam int INITN = SUBN - NLOG / 2;

  logic [PW-1:0] map_q  [NLOG];
  logic [SW-1:0] fl_q   [2][SUBN];
  logic [SW-1:0] head_q [2];
  logic [SW-1:0] tail_q [2];
  logic [CW-1:0] cnt_q  [2];

  logic [GRP-1:0] sel;
  logic [CW-1:0]  need   [2];
  logic [CW-1:0]  push_n [2];
  logic [PW-1:0]  dtag   [GRP];
  logic [SW-1:0]  rpos   [NREL];

  for (genvar g = 0; g < GRP; g++) begin : g_sel
    assign sel[g] = rr_mode ? 1'(g % 2) : subset_vec[g];
  end

  always_comb begin
    need[0] = '0;
    need[1] = '0;
    for (int i = 0; i < GRP; i++) begin
      dtag[i] = '0;
      if (ins_valid[i]) begin
        dtag[i] = {fl_q[sel[i]][head_q[sel[i]] + SW'(need[sel[i]])], sel[i]};
        need[sel[i]] = need[sel[i]] + CW'(1);
      end
    end
  end

  assign stall = (need[0] > cnt_q[0]) || (need[1] > cnt_q[1]);

  always_comb begin
    for (int i = 0; i < GRP; i++) begin
      logic [PW-1:0] ta, tb;
      ta = map_q[src_a_log[i*LW +: LW]];
      tb = map_q[src_b_log[i*LW +: LW]];
      for (int j = 0; j < GRP; j++) begin
        if (j < i && ins_valid[j]) begin
          if (dst_log[j*LW +: LW] == src_a_log[i*LW +: LW]) ta = dtag[j];
          if (dst_log[j*LW +: LW] == src_b_log[i*LW +: LW]) tb = dtag[j];
        end
      end
      src_a_phys[i*PW +: PW] = ta;
      src_b_phys[i*PW +: PW] = tb;
      dst_phys[i*PW +: PW]   = dtag[i];
    end
  end

  always_comb begin
    push_n[0] = '0;
    push_n[1] = '0;
    for (int k = 0; k < NREL; k++) begin
      rpos[k] = '0;
      if (rel_valid[k]) begin
        rpos[k] = tail_q[rel_tag[k*PW]] + SW'(push_n[rel_tag[k*PW]]);
        push_n[rel_tag[k*PW]] = push_n[rel_tag[k*PW]] + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLOG; l++) map_q[l] <= PW'(l);
      for (int s = 0; s < 2; s++) begin
        head_q[s] <= '0;
        tail_q[s] <= SW'(INITN);
        cnt_q[s]  <= CW'(INITN);
        for (int e = 0; e < SUBN; e++)
          fl_q[s][e] <= (e < INITN) ? SW'(e + NLOG / 2) : '0;
      end
    end else begin
      if (!stall)
        for (int i = 0; i < GRP; i++)
          if (ins_valid[i]) map_q[dst_log[i*LW +: LW]] <= dtag[i];
      for (int k = 0; k < NREL; k++)
        if (rel_valid[k]) fl_q[rel_tag[k*PW]][rpos[k]] <= rel_tag[k*PW+1 +: SW];
      for (int s = 0; s < 2; s++) begin
        head_q[s] <= head_q[s] + (stall ? '0 : SW'(need[s]));
        tail_q[s] <= tail_q[s] + SW'(push_n[s]);
        cnt_q[s]  <= cnt_q[s] - (stall ? '0 : need[s]) + push_n[s];
      end
    end
  end
endmodule

// File: rtl/ws_renamer_chk.sv
module ws_renamer_chk #(
  parameter int GRP  = 4,
  parameter int PW   = 5,
  parameter int CW   = 5,
  parameter int SUBN = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rr_mode,
  input logic [GRP-1:0]      ins_valid,
  input logic [GRP-1:0]      subset_vec,
  input logic [GRP*PW-1:0]   dst_phys,
  input logic                stall,
  input logic [1:0]          rel_valid,
  input logic [CW-1:0]       free_even,
  input logic [CW-1:0]       free_odd
);
  for (genvar g = 0; g < GRP; g++) begin : g_slot
    p_dst_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rr_mode && ins_valid[g] && !stall) |-> dst_phys[g*PW] == subset_vec[g]);
    p_rr_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_mode && ins_valid[g] && !stall) |-> dst_phys[g*PW] == 1'(g % 2));
    for (genvar h = g + 1; h < GRP; h++) begin : g_pair
      p_dst_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid[g] && ins_valid[h] && !stall) |-> dst_phys[g*PW +: PW] != dst_phys[h*PW +: PW]);
    end
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && rel_valid == '0) |=> (free_even == $past(free_even) && free_odd == $past(free_odd)));
  p_idle_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid == '0) |-> !stall);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (free_even <= CW'(SUBN)) && (free_odd <= CW'(SUBN)));
endmodule

bind ws_renamer ws_renamer_chk #(
  .GRP(GRP), .PW(PW), .CW(CW), .SUBN(SUBN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .ins_valid(ins_valid),
  .subset_vec(subset_vec), .dst_phys(dst_phys), .stall(stall),
  .rel_valid(rel_valid), .free_even(cnt_q[0]), .free_odd(cnt_q[1])
);

// File: tb/ws_renamer_tb.sv
module ws_renamer_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rr_mode = 0;
  logic [3:0]  ins_valid = 0, subset_vec = 0;
  logic [11:0] src_a_log = 0, src_b_log = 0, dst_log = 0;
  logic [1:0]  rel_valid = 0;
  logic [9:0]  rel_tag = 0;
  logic [19:0] src_a_phys, src_b_phys, dst_phys;
  logic        stall;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ws_renamer u_dut (.*);

  function automatic logic [11:0] pk(int s0, int s1, int s2, int s3);
    return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tg(logic [19:0] v, int i);
    return int'(v[i*5 +: 5]);
  endfunction

  task automatic grp(logic [3:0] v, logic [3:0] vec, logic [11:0] sa, logic [11:0] sb, logic [11:0] d);
    ins_valid = v; subset_vec = vec; src_a_log = sa; src_b_log = sb; dst_log = d;
    #2;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; rr_mode = 0; rel_valid = 0;
    grp(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_map();
    do_reset();
    grp(4'b0000, 0, pk(0, 1, 2, 3), pk(4, 5, 6, 7), 0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 src_a map", tg(src_a_phys, i), i);
      chk("R1 src_b map", tg(src_b_phys, i), 4 + i);
    end
    chk("R9 idle stall", stall, 0);
  endtask

  task automatic t_targeted();
    do_reset();
    grp(4'b1111, 4'b0101, 0, 0, pk(1, 2, 3, 4));
    chk("R2 slot0 odd", tg(dst_phys, 0), 9);
    chk("R2 slot1 even", tg(dst_phys, 1), 8);
    chk("R3 slot2 odd next", tg(dst_phys, 2), 11);
    chk("R3 slot3 even next", tg(dst_phys, 3), 10);
    step();
    grp(4'b1111, 4'b0000, 0, 0, pk(5, 6, 7, 0));
    for (int i = 0; i < 4; i++) chk("R4 continue even", tg(dst_phys, i), 12 + 2 * i);
    step();
    grp(4'b0000, 0, pk(1, 2, 3, 4), pk(5, 6, 7, 0), 0);
    chk("R6 map l1", tg(src_a_phys, 0), 9);
    chk("R6 map l2", tg(src_a_phys, 1), 8);
    chk("R6 map l3", tg(src_a_phys, 2), 11);
    chk("R6 map l4", tg(src_a_phys, 3), 10);
    for (int i = 0; i < 4; i++) chk("R6 map second group", tg(src_b_phys, i), 12 + 2 * i);
  endtask

  task automatic t_bypass();
    do_reset();
    grp(4'b1111, 4'b1010, pk(3, 3, 3, 3), pk(0, 0, 5, 5), pk(3, 3, 5, 2));
    chk("R2 dst s0", tg(dst_phys, 0), 8);
    chk("R2 dst s1", tg(dst_phys, 1), 9);
    chk("R2 dst s2", tg(dst_phys, 2), 10);
    chk("R2 dst s3", tg(dst_phys, 3), 11);
    chk("R5 slot0 reads map", tg(src_a_phys, 0), 3);
    chk("R5 slot1 bypass", tg(src_a_phys, 1), 8);
    chk("R5 slot2 youngest", tg(src_a_phys, 2), 9);
    chk("R5 slot3 youngest", tg(src_a_phys, 3), 9);
    chk("R5 no writer", tg(src_b_phys, 1), 0);
    chk("R5 own dst not bypassed", tg(src_b_phys, 2), 5);
    chk("R5 slot3 src_b bypass", tg(src_b_phys, 3), 10);
    step();
    grp(4'b0000, 0, pk(3, 5, 2, 0), 0, 0);
    chk("R6 youngest wins l3", tg(src_a_phys, 0), 9);
    chk("R6 map l5", tg(src_a_phys, 1), 10);
    chk("R6 map l2", tg(src_a_phys, 2), 11);
    chk("R6 unwritten l0", tg(src_a_phys, 3), 0);
  endtask

  task automatic t_invalid();
    do_reset();
    grp(4'b0101, 4'b0000, pk(0, 0, 2, 1), 0, pk(1, 2, 4, 6));
    chk("R7 slot0 dst", tg(dst_phys, 0), 8);
    chk("R7 invalid slot skipped", tg(dst_phys, 2), 10);
    chk("R7 invalid not bypass", tg(src_a_phys, 2), 2);
    step();
    grp(4'b0001, 4'b0000, pk(2, 1, 4, 2), 0, pk(7, 0, 0, 0));
    chk("R7 only two popped", tg(dst_phys, 0), 12);
    chk("R7 invalid no map write", tg(src_a_phys, 0), 2);
    chk("R6 map l1", tg(src_a_phys, 1), 8);
    chk("R6 map l4", tg(src_a_phys, 2), 10);
  endtask

  task automatic t_round_robin();
    do_reset();
    rr_mode = 1;
    grp(4'b1111, 4'b0000, 0, 0, pk(0, 1, 2, 3));
    for (int i = 0; i < 4; i++) chk("R8 rr vec 0000", tg(dst_phys, i), 8 + i);
    step();
    grp(4'b1111, 4'b1111, 0, 0, pk(4, 5, 6, 7));
    for (int i = 0; i < 4; i++) chk("R8 rr vec 1111", tg(dst_phys, i), 12 + i);
    step();
    rr_mode = 0;
  endtask

  task automatic t_stall_release();
    do_reset();
    for (int n = 0; n < 3; n++) begin
      grp(4'b1111, 4'b0000, 0, 0, pk(1, 2, 3, 4));
      chk("R9 enough entries", stall, 0);
      step();
    end
    grp(4'b1111, 4'b0000, 0, 0, pk(0, 5, 6, 7));
    chk("R9 even list empty", stall, 1);
    step();
    grp(4'b0011, 4'b0010, 0, 0, pk(0, 5, 0, 0));
    chk("R9 one subset short", stall, 1);
    step();
    grp(4'b0001, 4'b0001, pk(0, 5, 1, 4), 0, pk(0, 0, 0, 0));
    chk("R9 odd still served", stall, 0);
    chk("R9 odd list untouched", tg(dst_phys, 0), 9);
    chk("R9 stalled no map l0", tg(src_a_phys, 0), 0);
    chk("R9 stalled no map l5", tg(src_a_phys, 1), 5);
    chk("R6 map l1 after drain", tg(src_a_phys, 2), 24);
    chk("R6 map l4 after drain", tg(src_a_phys, 3), 30);
    step();
    rel_valid = 2'b11; rel_tag = {5'd30, 5'd8};
    grp(4'b0001, 4'b0000, 0, 0, 0);
    chk("R11 release not same cycle", stall, 1);
    step();
    grp(4'b0011, 4'b0000, 0, 0, pk(1, 2, 0, 0));
    chk("R10 released usable", stall, 0);
    chk("R10 port0 first", tg(dst_phys, 0), 8);
    chk("R10 port1 second", tg(dst_phys, 1), 30);
    step();
    rel_valid = 2'b11; rel_tag = {5'd16, 5'd3};
    grp(4'b0000, 0, 0, 0, 0);
    step();
    grp(4'b0011, 4'b0000, 0, 0, 0);
    chk("R10 only one even returned", stall, 1);
    grp(4'b0011, 4'b0010, 0, 0, 0);
    chk("R10 mixed release stall", stall, 0);
    chk("R10 even by low bit", tg(dst_phys, 0), 16);
    chk("R10 odd tail order", tg(dst_phys, 1), 11);
    step();
  endtask

  initial begin
    t_reset_map();
    t_targeted();
    t_bypass();
    t_invalid();
    t_round_robin();
    t_stall_release();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule